// File: doc/BRIEF.md
# Size-aware integer multiply step unit

This unit carries out the multiply steps of a microcoded integer datapath. Each step takes two 64-bit source register values and the current value of the destination register. It also takes a 2-bit step selector and a 2-bit operand-size code. From these it produces the new destination value one clock later. The operand size can be 1, 2, 4 or 8 bytes.

Four steps are provided:

- Two widening steps multiply the lower halves of the operand width and return a product of the full width. One treats the halves as unsigned values and the other as signed values.
- A low-product step returns the product truncated to the operand width.
- A high-product step returns the upper half of the exact unsigned double-width product.

A one-operand wide multiply is sequenced as two steps. The high-product step writes the high destination register first, then the low-product step writes the accumulator. A byte one-operand multiply is a single widening step at the 2-byte size. Two 8-bit values then give a 16-bit accumulator result.

Every result is merged into the old destination value according to the size:

| Size | What is written |
|------|-----------------|
| 1 or 2 bytes | Only the low bytes; the bits above them keep their old value |
| 4 bytes | The 32-bit result, zero-extended to 64 bits |
| 8 bytes | The whole register |

Top module: `mulop_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `dst_new` is 0.
- R2: `out_valid` equals `in_valid` of the previous cycle. `dst_new` changes only in the cycle after `in_valid` is high, and otherwise holds its value.
- R3: With `op_sel` = 2'b00, each source is masked to its low n/2 bits, where n = 8 × size in bytes. The two masked values are multiplied as unsigned values, and the n-bit product is the result.
- R4: With `op_sel` = 2'b01, each source is sign-extended from its own bit n/2 − 1. The values are multiplied, and the low n bits of the product are the result.
- R5: With `op_sel` = 2'b10, the result is the low n bits of `src_a` × `src_b`.
- R6: With `op_sel` = 2'b11, the result is exactly bits [2n−1:n] of the unsigned 2n-bit product of the two n-bit operands. This includes every carry out of the cross terms and out of the low × low term.
- R7: `size_sel` 2'b00 selects 1 byte and 2'b01 selects 2 bytes. At these sizes, `dst_new` bits above bit n−1 equal the same bits of `dst_old`.
- R8: `size_sel` 2'b10 selects 4 bytes. `dst_new[63:32]` is 0 and `dst_new[31:0]` is the result.
- R9: `size_sel` 2'b11 selects 8 bytes, and all 64 bits of `dst_new` are the result.
- R10: A widening step at the 2-byte size multiplies the low 8 bits of each source into a 16-bit value. For example, unsigned 0xFF × 0xFF gives 0xFE01, and signed 0xFF × 0x80 gives 0x0080. The destination bits above bit 15 are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A step is presented this cycle |
| op_sel | input | 2 | Step: 00 half unsigned, 01 half signed, 10 low product, 11 high product |
| size_sel | input | 2 | Operand size: 00 1 byte, 01 2 bytes, 10 4 bytes, 11 8 bytes |
| src_a | input | 64 | First source value |
| src_b | input | 64 | Second source value |
| dst_old | input | 64 | Current destination value |
| out_valid | output | 1 | `dst_new` holds a fresh result |
| dst_new | output | 64 | Merged destination value |

## Verification
The hardest case to reach is a high-product step at 8 bytes in which both cross terms and the low × low term overflow into the upper half together. Random values seldom produce this in a way that shows a dropped carry. The stimulus therefore applies all-ones operands, whose high product is exactly 0xFFFFFFFFFFFFFFFE, and operands whose 32-bit halves sit just below a power of two. These are driven at every size against a 128-bit reference in the bench. The sign-extension point of the signed widening step is reached the same way, with operands whose bit n/2 − 1 is set while the bits above it hold unrelated values.

// File: rtl/mulop_unit.sv
module mulop_unit #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [1:0]      op_sel,
  input  logic [1:0]      size_sel,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic [XLEN-1:0] dst_old,
  output logic            out_valid,
  output logic [XLEN-1:0] dst_new
);

  localparam int HW = XLEN / 2;

  logic [6:0]        nbits;
  logic [5:0]        sbit;
  logic [XLEN-1:0]   mask_n, mask_h;
  logic [XLEN-1:0]   a_n, b_n;
  logic [XLEN-1:0]   p_ll, p_lh, p_hl, p_hh;
  logic [2*XLEN-1:0] full;
  logic [XLEN-1:0]   hu_a, hu_b, hs_a, hs_b;
  logic [XLEN-1:0]   res_hu, res_hs, res_lo, res_hi, res;
  logic [XLEN-1:0]   merged;

  always_comb begin
    case (size_sel)
      2'b00:   nbits = 7'd8;
      2'b01:   nbits = 7'd16;
      2'b10:   nbits = 7'd32;
      default: nbits = 7'd64;
    endcase
  end

  assign sbit   = 6'((nbits >> 1) - 7'd1);
  assign mask_n = {XLEN{1'b1}} >> (XLEN - int'(nbits));
  assign mask_h = {XLEN{1'b1}} >> (XLEN - int'(nbits >> 1));

  assign a_n = src_a & mask_n;
  assign b_n = src_b & mask_n;

  assign p_ll = {{HW{1'b0}}, a_n[HW-1:0]}    * {{HW{1'b0}}, b_n[HW-1:0]};
  assign p_lh = {{HW{1'b0}}, a_n[HW-1:0]}    * {{HW{1'b0}}, b_n[XLEN-1:HW]};
  assign p_hl = {{HW{1'b0}}, a_n[XLEN-1:HW]} * {{HW{1'b0}}, b_n[HW-1:0]};
  assign p_hh = {{HW{1'b0}}, a_n[XLEN-1:HW]} * {{HW{1'b0}}, b_n[XLEN-1:HW]};

  assign full = {p_hh, p_ll}
              + {{HW{1'b0}}, p_lh, {HW{1'b0}}}
              + {{HW{1'b0}}, p_hl, {HW{1'b0}}};

  assign res_lo = full[XLEN-1:0];
  assign res_hi = XLEN'(full >> nbits);

  assign hu_a = src_a & mask_h;
  assign hu_b = src_b & mask_h;
  assign hs_a = src_a[sbit] ? (src_a | ~mask_h) : hu_a;
  assign hs_b = src_b[sbit] ? (src_b | ~mask_h) : hu_b;

  assign res_hu = hu_a * hu_b;
  assign res_hs = hs_a * hs_b;

  always_comb begin
    case (op_sel)
      2'b00:   res = res_hu;
      2'b01:   res = res_hs;
      2'b10:   res = res_lo;
      default: res = res_hi;
    endcase
  end

  always_comb begin
    case (size_sel)
      2'b00:   merged = {dst_old[XLEN-1:8], res[7:0]};
      2'b01:   merged = {dst_old[XLEN-1:16], res[15:0]};
      2'b10:   merged = {{(XLEN-32){1'b0}}, res[31:0]};
      default: merged = res;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dst_new   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) dst_new <= merged;
    end
  end

endmodule

// File: rtl/mulop_unit_chk.sv
module mulop_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [1:0]      size_sel,
  input logic [XLEN-1:0] dst_old,
  input logic            out_valid,
  input logic [XLEN-1:0] dst_new
);

  always_comb begin
    if (!rst_n) begin
      p_reset_clear_r1: assert (!out_valid && dst_new == '0);
    end
  end

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(dst_new)));

  p_byte_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size_sel == 2'b00) |=> dst_new[XLEN-1:8] == $past(dst_old[XLEN-1:8]));

  p_half_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size_sel == 2'b01) |=> dst_new[XLEN-1:16] == $past(dst_old[XLEN-1:16]));

  p_word_zext_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size_sel == 2'b10) |=> dst_new[XLEN-1:32] == '0);

endmodule

bind mulop_unit mulop_unit_chk #(.XLEN(XLEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size_sel(size_sel),
  .dst_old(dst_old), .out_valid(out_valid), .dst_new(dst_new)
);

// File: tb/mulop_unit_tb.sv
module mulop_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op_sel = 2'b00;
  logic [1:0]  size_sel = 2'b00;
  logic [63:0] src_a = '0, src_b = '0, dst_old = '0;
  logic        out_valid;
  logic [63:0] dst_new;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  always #2 clk = ~clk;

  mulop_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .size_sel(size_sel), .src_a(src_a), .src_b(src_b), .dst_old(dst_old),
    .out_valid(out_valid), .dst_new(dst_new)
  );

  function automatic logic [63:0] model(logic [1:0] op, logic [1:0] sz,
                                        logic [63:0] a, logic [63:0] b,
                                        logic [63:0] d);
    int n, h;
    logic [63:0] m, mh, r;
    logic [127:0] prod;
    logic signed [63:0] sa, sb;
    n  = 8 << sz;
    h  = n / 2;
    m  = (n == 64) ? '1 : ((64'd1 << n) - 64'd1);
    mh = (64'd1 << h) - 64'd1;
    prod = {64'd0, a & m} * {64'd0, b & m};
    sa = $signed(a << (64 - h));
    sa = sa >>> (64 - h);
    sb = $signed(b << (64 - h));
    sb = sb >>> (64 - h);
    case (op)
      2'b00:   r = (a & mh) * (b & mh);
      2'b01:   r = 64'(sa * sb);
      2'b10:   r = prod[63:0];
      default: r = 64'(prod >> n);
    endcase
    case (sz)
      2'b00:   return {d[63:8], r[7:0]};
      2'b01:   return {d[63:16], r[15:0]};
      2'b10:   return {32'd0, r[31:0]};
      default: return r;
    endcase
  endfunction

  function automatic logic [63:0] nextrand(logic [63:0] s);
    logic [63:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 7);
    return x ^ (x << 17);
  endfunction

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(logic [1:0] op, logic [1:0] sz,
                       logic [63:0] a, logic [63:0] b, logic [63:0] d);
    @(negedge clk);
    op_sel = op; size_sel = sz; src_a = a; src_b = b; dst_old = d;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic string tag_of(logic [1:0] op);
    case (op)
      2'b00:   return "R3";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic t_reset;
    #1;
    check("R1 out_valid", {63'd0, out_valid}, 64'd0);
    check("R1 dst_new", dst_new, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_sweep;
    logic [63:0] pats [6];
    pats[0] = '1;
    pats[1] = 64'h8000_0000_8000_0000;
    pats[2] = 64'hFFFF_FFFE_FFFF_FFFF;
    pats[3] = 64'h0123_4567_89AB_CDEF;
    pats[4] = 64'h7F7F_7F7F_7F7F_7F7F;
    pats[5] = 64'h0000_0000_0000_0001;
    for (int op = 0; op < 4; op++)
      for (int sz = 0; sz < 4; sz++)
        for (int i = 0; i < 6; i++) begin
          logic [63:0] bb, dd, e;
          bb = pats[(i + 2) % 6];
          dd = 64'hA5A5_5A5A_C3C3_3C3C ^ pats[i];
          e  = model(2'(op), 2'(sz), pats[i], bb, dd);
          apply(2'(op), 2'(sz), pats[i], bb, dd);
          check(tag_of(2'(op)), dst_new, e);
        end
  endtask

  task automatic t_random;
    for (int k = 0; k < 400; k++) begin
      logic [63:0] a, b, d, e;
      logic [1:0] op, sz;
      seed = nextrand(seed); a = seed;
      seed = nextrand(seed); b = seed;
      seed = nextrand(seed); d = seed;
      op = seed[1:0]; sz = seed[5:4];
      e = model(op, sz, a, b, d);
      apply(op, sz, a, b, d);
      check(tag_of(op), dst_new, e);
    end
  endtask

  task automatic t_high_carry;
    apply(2'b11, 2'b11, '1, '1, 64'h1234);
    check("R6 all-ones 8B", dst_new, 64'hFFFF_FFFF_FFFF_FFFE);
    apply(2'b11, 2'b10, 64'hFFFF_FFFF, 64'hFFFF_FFFF, '1);
    check("R6/R8 all-ones 4B", dst_new, 64'h0000_0000_FFFF_FFFE);
    apply(2'b11, 2'b00, 64'h55, 64'h66, 64'hDEAD_BEEF_0000_0000);
    check("R6/R7 byte high", dst_new, 64'hDEAD_BEEF_0000_0021);
  endtask

  task automatic t_merge;
    apply(2'b10, 2'b00, 64'h3, 64'h5, 64'hFEDC_BA98_7654_3210);
    check("R7 byte keep", dst_new, 64'hFEDC_BA98_7654_320F);
    apply(2'b10, 2'b01, 64'h100, 64'h100, 64'hFEDC_BA98_7654_3210);
    check("R7 half keep", dst_new, 64'hFEDC_BA98_7654_0000);
    apply(2'b10, 2'b10, 64'h2, 64'h8000_0001, '1);
    check("R8 zero-extend", dst_new, 64'h0000_0000_0000_0002);
    apply(2'b10, 2'b11, 64'h1_0000_0000, 64'h3_0000_0001, 64'h0);
    check("R9 whole write", dst_new, 64'h0000_0001_0000_0000);
  endtask

  task automatic t_byte_form;
    apply(2'b00, 2'b01, 64'h1234_56FF, 64'hAB_CDFF, 64'h1111_2222_3333_4444);
    check("R10 unsigned byte", dst_new, 64'h1111_2222_3333_FE01);
    apply(2'b01, 2'b01, 64'h77FF, 64'h9980, 64'h1111_2222_3333_4444);
    check("R10 signed byte", dst_new, 64'h1111_2222_3333_0080);
    apply(2'b01, 2'b11, 64'h8000_0000, 64'h2, 64'h0);
    check("R4 signed 8B", dst_new, 64'hFFFF_FFFF_0000_0000);
  endtask

  task automatic t_idle;
    logic [63:0] held;
    apply(2'b10, 2'b11, 64'd7, 64'd9, 64'd0);
    check("R2 out_valid high", {63'd0, out_valid}, 64'd1);
    held = dst_new;
    src_a = 64'hFFFF; src_b = 64'hFFFF; dst_old = '1; op_sel = 2'b11;
    @(negedge clk);
    check("R2 out_valid low", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    check("R2 hold", dst_new, held);
  endtask

  initial begin
    t_reset();
    t_sweep();
    t_high_carry();
    t_merge();
    t_byte_form();
    t_random();
    t_idle();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule